// File: doc/BRIEF.md
# LCD Panel Scan Timing Generator

This block produces the complete scan timing for a 640 by 480 parallel RGB LCD panel from one continuously running pixel clock. Two counters walk across every line and every frame. From their values the block derives an active-low horizontal sync, an active-low vertical sync, an active-high data enable and a one-cycle frame-start marker. All of these leave the block from registers that change on the rising clock edge, which keeps them steady around the falling edge on which the panel samples them. The horizontal sync keeps pulsing on every line, including the lines of vertical blanking.

An upstream pixel source reads the coordinate outputs and the fetch request. When the fetch request is high in a cycle, the coordinates name the pixel that will be shown next, and the source must place that pixel's colour on the pixel input in the same cycle. On the next edge the block registers the colour onto the panel bus together with the data enable. Outside the visible area the colour bus is held at zero.

The porch widths and sync widths are parameters. Sync widths below the panel's minimum are raised to that minimum. A parameter set whose visible area is not exactly 640 by 480, or whose porches fall below the panel's minimums, stops elaboration. With the defaults a line is 800 clocks and a frame is 525 lines. The block has one synchronous, active-high reset.

Top module: `panel_scan_gen`

## Requirements
- R1: While reset is held, after each rising edge: both syncs are 1, data enable is 0, fetch request is 0, frame start is 0, the pixel bus is 0, the column output is 0 and the line output is 480 (the first blanking line).
- R2: The column output counts up by one on every clock, from 0 to 799. When it wraps to 0, the line output advances by one, counting from 0 to 524 and then back to 0. The line output changes only when the column wraps.
- R3: Data enable is 1 in a cycle exactly when, one cycle earlier, the column was below 640 and the line was below 480.
- R4: Fetch request is 1 exactly when the current column is below 640 and the current line is below 480. It therefore leads data enable by one cycle.
- R5: Horizontal sync is 0 in a cycle exactly when, one cycle earlier, the column lay in 656..751 (96 clocks). This holds on every line, blanking lines included.
- R6: Vertical sync is 0 in a cycle exactly when, one cycle earlier, the line lay in 490..492. The 2-line default is raised to the 3-line minimum, so the pulse is 3 full lines, and it changes only in the cycle after a column wrap.
- R7: The pixel bus (red in the top 8 bits, green in the middle 8, blue in the low 8) equals the pixel input sampled one edge earlier whenever data enable is 1, and is 0 whenever data enable is 0.
- R8: Frame start is a one-cycle pulse that coincides with the first data-enable cycle of each frame, the one for column 0 of line 0.
- R9: A reset raised in the middle of a visible line returns every output to its R1 value at the next rising edge. After release, counting restarts from column 0 of line 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pixIn | input | 24 | Colour for the pixel named by the coordinates while fetch request is high |
| hSyncN | output | 1 | Horizontal sync to the panel, active low |
| vSyncN | output | 1 | Vertical sync to the panel, active low |
| dataEn | output | 1 | Data enable to the panel, active high during visible pixels |
| pixOut | output | 24 | Registered colour bus to the panel, zero outside the visible area |
| fetchReq | output | 1 | High one cycle before each visible pixel appears on the panel bus |
| pixelX | output | 10 | Current column count, the pixel to be supplied while fetch request is high |
| lineY | output | 10 | Current line count |
| frameStart | output | 1 | One-cycle pulse with the first visible pixel of a frame |

## Verification
The column, line and fetch-request outputs come straight from the counter registers, so they are due in the same cycle as the counter state they reflect. The syncs, data enable and frame start carry one register stage and are due one cycle after the coordinates that produced them. The pixel bus is due one edge after the input value it copies. The bench steps a reference pair of counters once per clock and keeps the previous pair and the last driven colour. At each falling edge it compares every output: the fetch request and coordinates against the current pair, and the other outputs against the previous pair. This keeps each comparison on the cycle in which its result is due. The run starts at the top of vertical blanking, crosses the vertical sync, the frame wrap and forty visible lines, then applies a mid-line reset and resynchronises the reference.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;

  // Fixed visible geometry and lower bounds the panel imposes.
  localparam int PANEL_COLS = 640;
  localparam int PANEL_ROWS = 480;
  localparam int MIN_H_FRONT = 0;
  localparam int MIN_H_BACK  = 7;
  localparam int MIN_H_SYNC  = 5;
  localparam int MIN_V_FRONT = 1;
  localparam int MIN_V_BACK  = 8;
  localparam int MIN_V_SYNC  = 3;

  // Strobes computed by the control from the counters, registered by the datapath.
  typedef struct packed {
    logic inView;      // current coordinates lie in the visible area
    logic inViewNext;  // coordinates after this edge lie in the visible area
    logic hPulse;      // current column lies in the horizontal sync window
    logic vPulse;      // current line lies in the vertical sync window
    logic firstPixel;  // column 0 of line 0
  } scan_strobe_t;

  function automatic int raiseTo(input int value, input int floorVal);
    return (value < floorVal) ? floorVal : value;
  endfunction

endpackage

// File: rtl/panel_scan_ctrl.sv
module panel_scan_ctrl
  import panel_scan_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 3,
  parameter int V_BACK   = 32,
  parameter int X_W      = 10,
  parameter int Y_W      = 10
) (
  input  logic           clk,
  input  logic           rst,
  output logic [X_W-1:0] hCnt,
  output logic [Y_W-1:0] vCnt,
  output scan_strobe_t   strobes
);

  localparam int H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HS_FIRST = H_ACTIVE + H_FRONT;
  localparam int HS_STOP  = HS_FIRST + H_SYNC;
  localparam int VS_FIRST = V_ACTIVE + V_FRONT;
  localparam int VS_STOP  = VS_FIRST + V_SYNC;

  localparam logic [X_W-1:0] H_LAST    = X_W'(H_TOTAL - 1);
  localparam logic [Y_W-1:0] V_LAST    = Y_W'(V_TOTAL - 1);
  localparam logic [X_W-1:0] H_VIS_END = X_W'(H_ACTIVE);
  localparam logic [Y_W-1:0] V_VIS_END = Y_W'(V_ACTIVE);
  localparam logic [X_W-1:0] HS_LO     = X_W'(HS_FIRST);
  localparam logic [X_W-1:0] HS_HI     = X_W'(HS_STOP);
  localparam logic [Y_W-1:0] VS_LO     = Y_W'(VS_FIRST);
  localparam logic [Y_W-1:0] VS_HI     = Y_W'(VS_STOP);

  logic           lineEnd;
  logic           frameEnd;
  logic [X_W-1:0] hNext;
  logic [Y_W-1:0] vNext;

  always_comb begin
    lineEnd  = (hCnt == H_LAST);
    frameEnd = (vCnt == V_LAST);
    hNext    = lineEnd ? '0 : hCnt + X_W'(1);
    if (!lineEnd)
      vNext = vCnt;
    else if (frameEnd)
      vNext = '0;
    else
      vNext = vCnt + Y_W'(1);
  end

  // Reset parks the scan at the first blanking line.
  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= V_VIS_END;
    end else begin
      hCnt <= hNext;
      vCnt <= vNext;
    end
  end

  always_comb begin
    strobes.inView     = (hCnt < H_VIS_END) && (vCnt < V_VIS_END);
    strobes.inViewNext = (hNext < H_VIS_END) && (vNext < V_VIS_END);
    strobes.hPulse     = (hCnt >= HS_LO) && (hCnt < HS_HI);
    strobes.vPulse     = (vCnt >= VS_LO) && (vCnt < VS_HI);
    strobes.firstPixel = (hCnt == '0) && (vCnt == '0);
  end

  // R2: column never leaves its range.
  p_col_range_r2: assert property (@(posedge clk) disable iff (rst)
    hCnt <= H_LAST);

  // R2: every nonzero column follows its predecessor by one.
  p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
    (hCnt != '0 && !$past(rst)) |-> hCnt == $past(hCnt) + X_W'(1));

  // R2: the line holds still except at a column wrap.
  p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (hCnt != '0 && !$past(rst)) |-> $stable(vCnt));

  // R2: line 0 is entered only from the last line.
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (hCnt == '0 && vCnt == '0 && !$past(rst)) |-> $past(vCnt) == V_LAST);

endmodule

// File: rtl/panel_scan_dp.sv
module panel_scan_dp
  import panel_scan_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  scan_strobe_t     strobes,
  input  logic [PIX_W-1:0] pixIn,
  output logic             hSyncN,
  output logic             vSyncN,
  output logic             dataEn,
  output logic [PIX_W-1:0] pixOut,
  output logic             fetchReq,
  output logic             frameStart
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hSyncN     <= 1'b1;
      vSyncN     <= 1'b1;
      dataEn     <= 1'b0;
      pixOut     <= '0;
      fetchReq   <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      hSyncN     <= ~strobes.hPulse;
      vSyncN     <= ~strobes.vPulse;
      dataEn     <= strobes.inView;
      pixOut     <= strobes.inView ? pixIn : '0;
      fetchReq   <= strobes.inViewNext;
      frameStart <= strobes.firstPixel;
    end
  end

  // R7: colour bus is blank whenever the enable is low.
  p_blank_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !dataEn |-> pixOut == '0);

  // R4: the enable follows the fetch request by exactly one cycle.
  p_fetch_lead_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dataEn == $past(fetchReq));

  // R8: frame start lasts a single cycle.
  p_frame_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

  // R8: frame start marks a visible pixel.
  p_frame_visible_r8: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> dataEn);

endmodule

// File: rtl/panel_scan_gen.sv
module panel_scan_gen
  import panel_scan_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int H_FRONT    = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BACK     = 48,
  parameter int V_ACTIVE   = 480,
  parameter int V_FRONT    = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BACK     = 32,
  parameter int COLOR_BITS = 8,
  localparam int H_SYNC_W  = raiseTo(H_SYNC, MIN_H_SYNC),
  localparam int V_SYNC_W  = raiseTo(V_SYNC, MIN_V_SYNC),
  localparam int H_TOTAL   = H_ACTIVE + H_FRONT + H_SYNC_W + H_BACK,
  localparam int V_TOTAL   = V_ACTIVE + V_FRONT + V_SYNC_W + V_BACK,
  localparam int X_W       = $clog2(H_TOTAL),
  localparam int Y_W       = $clog2(V_TOTAL),
  localparam int PIX_W     = 3 * COLOR_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pixIn,
  output logic             hSyncN,
  output logic             vSyncN,
  output logic             dataEn,
  output logic [PIX_W-1:0] pixOut,
  output logic             fetchReq,
  output logic [X_W-1:0]   pixelX,
  output logic [Y_W-1:0]   lineY,
  output logic             frameStart
);

  // Parameter sets the panel cannot accept stop elaboration.
  if (H_ACTIVE != PANEL_COLS || V_ACTIVE != PANEL_ROWS) begin : g_badSize
    $error("visible area must be 640 x 480");
  end
  if (H_FRONT < MIN_H_FRONT || H_BACK < MIN_H_BACK) begin : g_badHPorch
    $error("horizontal porch below panel minimum");
  end
  if (V_FRONT < MIN_V_FRONT || V_BACK < MIN_V_BACK) begin : g_badVPorch
    $error("vertical porch below panel minimum");
  end

  scan_strobe_t   scanStrobes;
  logic [X_W-1:0] hCnt;
  logic [Y_W-1:0] vCnt;

  panel_scan_ctrl #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC_W), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC_W), .V_BACK(V_BACK),
    .X_W(X_W), .Y_W(Y_W)
  ) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .hCnt   (hCnt),
    .vCnt   (vCnt),
    .strobes(scanStrobes)
  );

  panel_scan_dp #(.PIX_W(PIX_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (scanStrobes),
    .pixIn     (pixIn),
    .hSyncN    (hSyncN),
    .vSyncN    (vSyncN),
    .dataEn    (dataEn),
    .pixOut    (pixOut),
    .fetchReq  (fetchReq),
    .frameStart(frameStart)
  );

  assign pixelX = hCnt;
  assign lineY  = vCnt;

  // R6: vertical sync moves only in the cycle after a column wrap.
  p_vsync_on_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(vSyncN) && !$past(rst)) |-> pixelX == X_W'(1));

  // R3: the enable is never high during a sync pulse.
  p_de_outside_sync_r3: assert property (@(posedge clk) disable iff (rst)
    dataEn |-> (hSyncN && vSyncN));

endmodule

// File: tb/panel_scan_gen_tb_top.sv
`timescale 1ns/1ps
module panel_scan_gen_tb_top;

  localparam int CLK_PERIOD = 40;
  localparam int HA = 640, HT = 800, HS0 = 656, HS1 = 752;
  localparam int VA = 480, VT = 525, VS0 = 490, VS1 = 493;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pixIn = '0;
  logic        hSyncN, vSyncN, dataEn, fetchReq, frameStart;
  logic [23:0] pixOut;
  logic [9:0]  pixelX, lineY;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int curH, curV, prevH, prevV;
  logic [23:0] lastDriven;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_scan_gen dut_i (
    .clk(clk), .rst(rst), .pixIn(pixIn),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .dataEn(dataEn), .pixOut(pixOut),
    .fetchReq(fetchReq), .pixelX(pixelX), .lineY(lineY), .frameStart(frameStart)
  );

  function automatic bit visible(input int h, input int v);
    return (h < HA) && (v < VA);
  endfunction

  function automatic bit hWin(input int h);
    return (h >= HS0) && (h < HS1);
  endfunction

  function automatic bit vWin(input int v);
    return (v >= VS0) && (v < VS1);
  endfunction

  function automatic logic [23:0] pickPix();
    int sel = $urandom % 4;
    if (sel == 0) return 24'hFFFFFF;
    if (sel == 1) return 24'h000000;
    return 24'($urandom);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at col %0d line %0d: actual %0d expected %0d",
               tag, what, curH, curV, act, exp);
    end
  endtask

  // Expected reset state (R1 at start, R9 after a mid-line reset).
  task automatic checkResetState(input string tag);
    check(tag, "hSyncN", int'(hSyncN), 1);
    check(tag, "vSyncN", int'(vSyncN), 1);
    check(tag, "dataEn", int'(dataEn), 0);
    check(tag, "fetchReq", int'(fetchReq), 0);
    check(tag, "frameStart", int'(frameStart), 0);
    check(tag, "pixOut", int'(pixOut), 0);
    check(tag, "pixelX", int'(pixelX), 0);
    check(tag, "lineY", int'(lineY), VA);
  endtask

  task automatic stepRef();
    prevH = curH;
    prevV = curV;
    if (curH == HT - 1) begin
      curH = 0;
      curV = (curV == VT - 1) ? 0 : curV + 1;
    end else begin
      curH = curH + 1;
    end
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stepRef();
      check("R2", "pixelX", int'(pixelX), curH);
      check("R2", "lineY", int'(lineY), curV);
      check("R4", "fetchReq", int'(fetchReq), int'(visible(curH, curV)));
      check("R3", "dataEn", int'(dataEn), int'(visible(prevH, prevV)));
      check("R5", "hSyncN", int'(hSyncN), int'(!hWin(prevH)));
      check("R6", "vSyncN", int'(vSyncN), int'(!vWin(prevV)));
      check("R8", "frameStart", int'(frameStart), int'(prevH == 0 && prevV == 0));
      check("R7", "pixOut", int'(pixOut),
            visible(prevH, prevV) ? int'(lastDriven) : 0);
      lastDriven = pickPix();
      pixIn = lastDriven;
    end
  endtask

  task automatic releaseReset();
    curH = 0;
    curV = VA;
    lastDriven = pixIn;
    rst = 1'b0;
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(32'h1F2E3D);
    rst = 1'b1;
    pixIn = 24'hABCDEF;
    // R1: outputs during reset, with a nonzero colour on the input.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkResetState("R1");
    end
    releaseReset();
    // Blanking lines, vertical sync, frame wrap and forty visible lines.
    runCycles((VT - VA) * HT + 40 * HT + 123);
    // R9: reset raised in the middle of a visible line.
    check("R9", "dataEn before reset", int'(dataEn), 1);
    rst = 1'b1;
    pixIn = 24'h5A5A5A;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      checkResetState("R9");
    end
    releaseReset();
    runCycles(3 * HT + 17);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule